// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse Width Generator

This block produces up to two independent pulse-width-modulated outputs from a single clock. Software programs it through a small 32-bit register bus. A shared control word holds one field group per channel. Each group has a prescaler select, a run enable, an active-level select and a clock gate. Every channel also has its own word that holds the period length and the duty length, both counted in prescaled ticks.

Each channel divides the clock by a divisor taken from a fixed table. The divisors are not powers of two, a few codes are reserved, and one code passes the clock straight through. The channel counts ticks across the period and holds its output at the active level for the first duty ticks. A write to a period/duty word lands in a shadow copy. That copy is applied only at the end of the running period, so a waveform never shows a torn mix of old and new settings. A per-channel ready flag shows that such an update is still waiting.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset, the control word and every period/duty word read 0, every ready flag reads 0, and every output is high (stopped, with active state 0).
- R2: The control word is at byte offset 0x0 and channel n's period/duty word at 0x4 + 4*n. Channel n's group starts at bit 15*n: code in bits 3:0, enable in bit 4, active state in bit 5, clock gate in bit 6. Bits 9:7 of each group are stored and read back but have no effect. A period/duty word reads back the last value written to it.
- R3: Prescaler codes 0..4 give one tick every 120, 180, 240, 360 and 480 clocks. Codes 8..12 give one tick every 12000, 24000, 36000, 48000 and 72000 clocks. Code 15 gives a tick on every clock.
- R4: Codes 5, 6, 7, 13 and 14 are invalid. With such a code the channel produces no ticks and its output holds the inactive level, even while enable and gate are both 1.
- R5: A channel runs only while both its enable bit and its gate bit are 1. Otherwise its output sits at the inactive level, and its period position restarts from zero when it runs again.
- R6: Bits 31:16 of a period/duty word hold the period length in ticks minus one, and bits 15:0 hold the duty length in ticks. In each period the output is active for the first duty ticks and inactive for the rest.
- R7: A duty length equal to or greater than the period length keeps the output active for the whole period. A duty length of 0 keeps it inactive for the whole period.
- R8: With active state 1 the active level is high. With active state 0 the active level is low and the inactive level is high.
- R9: A write to the control word changes a channel's code only if that channel's stored gate bit was 0 before the write. The enable, active-state, gate and spare bits are always written.
- R10: A period/duty write goes to a shadow copy. The copy becomes active at the end of the current period while the channel runs, or on the next clock while it is stopped. Ready bit 28+n of the control word reads 1 from the clock after the write until the copy is made.
- R11: If a period/duty write arrives in the same clock as a period end, that period end applies the shadow value held before the write. The new value stays pending, with ready at 1, until the following period end.
- R12: The channel count parameter is 1 or 2. Channel 1 runs independently of channel 0, and its ready flag is bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
The two functions that can fall in the same clock are a software write of a period/duty word and the hardware end of a period, which copies the shadow into the active settings. The bench enables a channel with a ten-tick period at a known phase. It writes one update in mid-period, then writes a second update exactly on the clock that ends the period. It then judges the result by counting active samples over each of the next two periods, which must show the first and then the second duty. It also checks that the ready flag stays at 1 across the collision and drops only after the later period end.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned DIV_W   = 17;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned FIELD_W = 10;

  typedef struct packed {
    logic [2:0]        spare;
    logic              gate;
    logic              pol;
    logic              en;
    logic [CODE_W-1:0] code;
  } chan_ctrl_t;

  // clocks per tick for a code; 0 marks a reserved code
  function automatic logic [DIV_W-1:0] prescale_div(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return DIV_W'(120);
      4'd1:    return DIV_W'(180);
      4'd2:    return DIV_W'(240);
      4'd3:    return DIV_W'(360);
      4'd4:    return DIV_W'(480);
      4'd8:    return DIV_W'(12000);
      4'd9:    return DIV_W'(24000);
      4'd10:   return DIV_W'(36000);
      4'd11:   return DIV_W'(48000);
      4'd12:   return DIV_W'(72000);
      4'd15:   return DIV_W'(1);
      default: return '0;
    endcase
  endfunction

  // control field update: the code is locked while the stored gate is set
  function automatic chan_ctrl_t next_ctrl(input chan_ctrl_t cur, input chan_ctrl_t req);
    chan_ctrl_t r;
    r = req;
    if (cur.gate) r.code = cur.code;
    return r;
  endfunction

  function automatic logic in_duty(input logic [CNT_W-1:0] pos, input logic [CNT_W-1:0] duty);
    return pos < duty;
  endfunction
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              valid,
  output logic              tick
);
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] cnt;
  logic             bypass;

  assign div    = prescale_div(code);
  assign valid  = (div != '0);
  assign bypass = (div == DIV_W'(1));
  assign tick   = run && valid && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || !valid)      cnt <= '0;
    else if (cnt == div - DIV_W'(1)) cnt <= '0;
    else                          cnt <= cnt + DIV_W'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bypass) |=> !tick);
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        valid,
  input  logic        tick,
  input  logic        pol,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] shadow_word,
  output logic        ready,
  output logic        out
);
  logic [CNT_W-1:0] act_prd, act_dty, sh_prd, sh_dty, pcnt;
  logic             pend;
  logic             on;
  logic             wrap;
  logic             load;
  logic             act_on;

  assign on     = run && valid;
  assign wrap   = tick && (pcnt == act_prd);
  assign load   = pend && (wrap || !on);
  assign act_on = on && in_duty(pcnt, act_dty);
  assign out    = pol ? act_on : !act_on;
  assign ready  = pend;
  assign shadow_word = {sh_prd, sh_dty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      act_prd <= '0;
      act_dty <= '0;
      sh_prd  <= '0;
      sh_dty  <= '0;
      pend    <= 1'b0;
    end else begin
      if (!on)       pcnt <= '0;
      else if (tick) pcnt <= wrap ? '0 : pcnt + CNT_W'(1);
      if (load) begin
        act_prd <= sh_prd;
        act_dty <= sh_dty;
      end
      if (wr) begin
        sh_prd <= wdata[31:16];
        sh_dty <= wdata[15:0];
        pend   <= 1'b1;
      end else if (load) begin
        pend   <= 1'b0;
      end
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (pcnt == '0));
  // R6
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= act_prd);
  // R10
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(wrap || !on));
  // R11
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wrap) |=> pend);
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int ADDR_W   = 4,
  parameter int STRIDE   = 15,
  parameter int RDY_BASE = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int WIDX_W = ADDR_W - 2;

  chan_ctrl_t        ctrl_q [NCH];
  logic [WIDX_W-1:0] widx;
  logic              ctrl_wr;
  logic [NCH-1:0]    ready;
  logic [31:0]       shadow_word [NCH];
  logic [31:0]       ctrl_rd;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign ctrl_wr = bus_wr && (widx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) ctrl_q[n] <= '0;
    end else if (ctrl_wr) begin
      for (int n = 0; n < NCH; n++)
        ctrl_q[n] <= next_ctrl(ctrl_q[n], chan_ctrl_t'(bus_wdata[STRIDE*n +: FIELD_W]));
    end
  end

  always_comb begin
    ctrl_rd = '0;
    for (int n = 0; n < NCH; n++) begin
      ctrl_rd[STRIDE*n +: FIELD_W] = ctrl_q[n];
      ctrl_rd[RDY_BASE+n]          = ready[n];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (widx == '0) bus_rdata = ctrl_rd;
    for (int n = 0; n < NCH; n++)
      if (widx == WIDX_W'(n + 1)) bus_rdata = shadow_word[n];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic run, valid, tick, ch_wr;
    assign run   = ctrl_q[n].en && ctrl_q[n].gate;
    assign ch_wr = bus_wr && (widx == WIDX_W'(n + 1));

    pwm2_prescaler u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .code  (ctrl_q[n].code),
      .valid (valid),
      .tick  (tick)
    );

    pwm2_channel u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .valid       (valid),
      .tick        (tick),
      .pol         (ctrl_q[n].pol),
      .wr          (ch_wr),
      .wdata       (bus_wdata),
      .shadow_word (shadow_word[n]),
      .ready       (ready[n]),
      .out         (pwm_out[n])
    );

    // R9
    code_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[n].gate |=> $stable(ctrl_q[n].code));
  end
endmodule

// File: tb/sim_pwm2_ctrl.sv
module sim_pwm2_ctrl;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pwm_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pwm2_ctrl #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int ch, input int code, input bit en,
                                     input bit pol, input bit gate);
    logic [31:0] w;
    w = '0;
    w[15*ch +: 7] = {gate, pol, en, 4'(code)};
    return w;
  endfunction

  function automatic logic [31:0] pdw(input int prd_m1, input int duty);
    return {16'(prd_m1), 16'(duty)};
  endfunction

  // called at a negedge, returns at the negedge after the capturing edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic count_high(input int ch, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) c++;
      @(negedge clk);
    end
  endtask

  // stops all channels, loads the word, enables ch; returns at tick phase 0
  task automatic start(input int ch, input int code, input bit pol,
                       input int prd_m1, input int duty);
    wr(4'h0, 32'h0);
    wr(4'(4 + 4*ch), pdw(prd_m1, duty));
    @(negedge clk);
    wr(4'h0, cw(ch, code, 1'b1, pol, 1'b1));
  endtask

  task automatic measure(input int ch, input int code, input bit pol, input int prd_m1,
                         input int duty, input int n, input int exp, input string tag);
    int c;
    start(ch, code, pol, prd_m1, duty);
    count_high(ch, n, c);
    chk(c == exp, tag, c, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d);  chk(d == 0, "R1 control word", int'(d), 0);
    rd(4'h4, d);  chk(d == 0, "R1 ch0 word", int'(d), 0);
    rd(4'h8, d);  chk(d == 0, "R1 ch1 word", int'(d), 0);
    chk(pwm_out == 2'b11, "R1 outputs high", int'(pwm_out), 3);
  endtask

  task automatic t_shadow_idle;
    logic [31:0] d;
    wr(4'h4, pdw(9, 3));
    rd(4'h0, d);  chk(d[28] == 1'b1, "R10 ready after write", int'(d[28]), 1);
    @(negedge clk);
    rd(4'h0, d);  chk(d[28] == 1'b0, "R10 ready cleared when stopped", int'(d[28]), 0);
    rd(4'h4, d);  chk(d == pdw(9, 3), "R2 word readback", int'(d), int'(pdw(9, 3)));
    wr(4'h0, 32'h0000_0380);
    rd(4'h0, d);  chk(d[9:0] == 10'h380, "R2 spare bits stored", int'(d[9:0]), 'h380);
    chk(pwm_out[0] == 1'b1, "R2 spare bits no effect", int'(pwm_out[0]), 1);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_waveforms;
    measure(0, 15, 1'b1, 9, 3, 20, 6, "R6 duty 3 of 10 normal");
    measure(0, 15, 1'b0, 9, 3, 10, 7, "R8 inverted polarity");
    measure(0, 15, 1'b1, 9, 20, 10, 10, "R7 duty over length");
    measure(0, 15, 1'b1, 9, 10, 10, 10, "R7 duty equal length");
    measure(0, 15, 1'b1, 9, 0, 10, 0, "R7 duty zero");
    measure(0, 0, 1'b1, 1, 1, 240, 120, "R3 code 0 divide 120");
    measure(0, 5, 1'b1, 9, 3, 50, 0, "R4 invalid code 5");
    measure(0, 13, 1'b0, 9, 3, 50, 50, "R4 invalid code 13 inverted");
  endtask

  task automatic t_phase_120;
    int c;
    start(0, 0, 1'b1, 1, 1);
    repeat (119) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R3 still active at clock 119", int'(pwm_out[0]), 1);
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R3 inactive at clock 120", int'(pwm_out[0]), 0);
    c = 0;
  endtask

  task automatic t_idle;
    int c;
    wr(4'h0, 32'h0);
    wr(4'h4, pdw(9, 5));
    @(negedge clk);
    wr(4'h0, cw(0, 15, 1'b0, 1'b1, 1'b1));
    count_high(0, 20, c);
    chk(c == 0, "R5 gate without enable", c, 0);
    wr(4'h0, cw(0, 15, 1'b1, 1'b1, 1'b0));
    count_high(0, 20, c);
    chk(c == 0, "R5 enable without gate", c, 0);
    wr(4'h0, cw(0, 15, 1'b1, 1'b1, 1'b1));
    count_high(0, 5, c);
    chk(c == 5, "R5 restart from position zero", c, 5);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_gate_rule;
    logic [31:0] d;
    wr(4'h0, cw(0, 15, 1'b1, 1'b1, 1'b1));
    rd(4'h0, d);  chk(d[3:0] == 4'd15, "R9 code taken with gate clear", int'(d[3:0]), 15);
    wr(4'h0, cw(0, 0, 1'b1, 1'b1, 1'b1));
    rd(4'h0, d);  chk(d[3:0] == 4'd15, "R9 code locked by gate", int'(d[3:0]), 15);
    wr(4'h0, cw(0, 0, 1'b1, 1'b1, 1'b0));
    rd(4'h0, d);
    chk(d[3:0] == 4'd15 && d[6] == 1'b0, "R9 gate clears, code still locked", int'(d[6:0]), 'h3F);
    wr(4'h0, cw(0, 0, 1'b1, 1'b1, 1'b1));
    rd(4'h0, d);  chk(d[3:0] == 4'd0, "R9 code taken after gate clear", int'(d[3:0]), 0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_running_update;
    logic [31:0] d;
    int c;
    start(0, 15, 1'b1, 9, 2);
    repeat (3) @(negedge clk);
    wr(4'h4, pdw(9, 6));
    rd(4'h0, d);  chk(d[28] == 1'b1, "R10 ready while running", int'(d[28]), 1);
    repeat (6) @(negedge clk);
    rd(4'h0, d);  chk(d[28] == 1'b0, "R10 ready clear after period end", int'(d[28]), 0);
    count_high(0, 20, c);
    chk(c == 12, "R10 new duty applied", c, 12);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    int c;
    start(0, 15, 1'b1, 9, 2);
    repeat (3) @(negedge clk);
    wr(4'h4, pdw(9, 5));
    repeat (5) @(negedge clk);
    wr(4'h4, pdw(9, 7));
    rd(4'h0, d);  chk(d[28] == 1'b1, "R11 ready kept across collision", int'(d[28]), 1);
    count_high(0, 10, c);
    chk(c == 5, "R11 earlier shadow applied", c, 5);
    rd(4'h0, d);  chk(d[28] == 1'b0, "R11 ready clear after next end", int'(d[28]), 0);
    count_high(0, 10, c);
    chk(c == 7, "R11 later write applied", c, 7);
  endtask

  task automatic t_ch1;
    logic [31:0] d;
    int c;
    wr(4'h0, 32'h0);
    wr(4'h8, pdw(3, 1));
    rd(4'h0, d);
    chk(d[29] == 1'b1 && d[28] == 1'b0, "R12 ch1 ready bit 29", int'(d[29:28]), 2);
    measure(1, 15, 1'b1, 3, 1, 8, 2, "R12 ch1 duty 1 of 4");
    chk(pwm_out[0] == 1'b1, "R12 ch0 idle while ch1 runs", int'(pwm_out[0]), 1);
    wr(4'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow_idle();
    t_waveforms();
    t_phase_120();
    t_idle();
    t_gate_rule();
    t_running_update();
    t_collision();
    t_ch1();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule